// File: doc/BRIEF.md
# Cartridge CPU Bus Decoder

This block sits on the cartridge side of a 6502-style console bus and tells the rest of the cartridge logic what the processor is doing. The console provides no A15 line. It provides only a ROM select that is low when both the phase-2 clock M2 and A15 are high, and that settles roughly 33 ns after M2 changes. The decoder works out the upper address bit from that signal and produces four outputs:

- a register write strobe for the expansion and work-RAM area;
- a configurable register-window hit;
- a work RAM chip enable;
- a ROM chip enable.

All bus inputs are sampled by a fast local clock. A write is taken at the M2 falling edge, using the values sampled in the last clock of the M2 high phase. ROM select has settled by then, so its lag cannot corrupt a capture. The captured address and data stay on the outputs until the next capture. The one-cycle `wr_stb` pulse marks each new capture. `win_stb` pulses with it when the address also lies inside the register window.

Top module: `cart_bus_decoder`

## Requirements
- R1: During and right after reset, `wr_stb` and `win_stb` are low and `wr_addr` and `wr_data` are zero.
- R2: A write is a cycle where `cpu_rw` is 0, `romsel_n` is 1 and `cpu_addr` is at least 0x4020, all as sampled in the last clock with M2 high. Each such write produces exactly one `wr_stb` pulse, one clock long. The pulse is high in the clock that follows the first clock edge that samples M2 low.
- R3: `wr_addr` and `wr_data` show the address and data sampled in the last clock of the M2 high phase of the captured write. Changes made while M2 is low do not affect them, and they hold until the next pulse.
- R4: A cycle with `romsel_n` low at the M2 falling edge (the $8000–$FFFF half) never produces a strobe. This holds even when `romsel_n` was still high, because of its lag, early in the high phase.
- R5: Read cycles (`cpu_rw` = 1) never produce a strobe.
- R6: Writes with A15 = 0 and an address below 0x4020 never produce a strobe.
- R7: `win_stb` pulses together with `wr_stb` exactly when (`wr_addr` & WIN_MASK) == WIN_MATCH. The default window is 0x5000–0x5FFF (mask 0x7000, match 0x5000).
- R8: `ram_ce` is high exactly when M2 is high, `romsel_n` is high and (`cpu_addr` & RAM_MASK) == RAM_MATCH, for reads and writes alike. The default is 0x6000–0x7FFF. It is low whenever M2 is low.
- R9: `rom_ce` is the inverse of `romsel_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m2 | input | 1 | Console phase-2 clock |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| romsel_n | input | 1 | NAND of M2 and A15, lagging M2 |
| cpu_addr | input | 15 | Address lines A0–A14 |
| cpu_data | input | 8 | Data bus |
| wr_stb | output | 1 | One-clock pulse on a captured register write |
| wr_addr | output | 15 | Address of the last captured write |
| wr_data | output | 8 | Data of the last captured write |
| win_stb | output | 1 | Pulse when the captured write hits the register window |
| ram_ce | output | 1 | Work RAM chip enable |
| rom_ce | output | 1 | ROM chip enable |

## Verification
The port assertions assume that all bus inputs change only between clock edges and stay stable through the last sampled clock of each M2 high phase. They also assume that an M2 high or low phase lasts longer than one clock. The stimulus drives every input on the falling clock edge. It keeps each M2 phase at ten or more clocks and lets `romsel_n` follow M2 eight clocks late in both directions, so the lag is present at every rising and falling edge of M2. The bench moves the address and data during the M2 low phase so that capture of stale values would show.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  localparam int unsigned BUS_AW = 16;

  // Inclusive range test on a zero-extended bus address.
  function automatic logic span_hit(input logic [BUS_AW-1:0] a,
                                    input logic [BUS_AW-1:0] lo,
                                    input logic [BUS_AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Masked compare: bits outside the mask are don't-care.
  function automatic logic mask_hit(input logic [BUS_AW-1:0] a,
                                    input logic [BUS_AW-1:0] mask,
                                    input logic [BUS_AW-1:0] match);
    return (a & mask) == (match & mask);
  endfunction

endpackage

// File: rtl/cbd_phase_sampler.sv
module cbd_phase_sampler #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m2,
  input  logic          rw,
  input  logic          rsel_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          s_rw,
  output logic          s_rsel_n,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_data,
  output logic          m2_fall
);

  logic s_m2;

  // Every clock the bus is copied; on the fall the copy is the last high sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_m2     <= 1'b0;
      s_rw     <= 1'b1;
      s_rsel_n <= 1'b1;
      s_addr   <= '0;
      s_data   <= '0;
    end else begin
      s_m2     <= m2;
      s_rw     <= rw;
      s_rsel_n <= rsel_n;
      s_addr   <= addr;
      s_data   <= data;
    end
  end

  assign m2_fall = s_m2 & ~m2;

endmodule

// File: rtl/cbd_write_capture.sv
module cbd_write_capture
  import cbd_pkg::*;
#(
  parameter int unsigned AW        = 15,
  parameter int unsigned DW        = 8,
  parameter logic [15:0] REG_LO    = 16'h4020,
  parameter logic [15:0] REG_HI    = 16'h7FFF,
  parameter logic [15:0] WIN_MASK  = 16'h7000,
  parameter logic [15:0] WIN_MATCH = 16'h5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m2_fall,
  input  logic          s_rw,
  input  logic          s_rsel_n,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_data,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          win_stb
);

  localparam int unsigned PADW = BUS_AW - AW;

  logic [BUS_AW-1:0] s_addr_x;
  logic [BUS_AW-1:0] wr_addr_x;
  logic              cap_take;
  logic              cap_win;

  // A15 is zero whenever the ROM select is high at the fall.
  assign s_addr_x  = {{PADW{1'b0}}, s_addr};
  assign wr_addr_x = {{PADW{1'b0}}, wr_addr};
  assign cap_take  = m2_fall & ~s_rw & s_rsel_n & span_hit(s_addr_x, REG_LO, REG_HI);
  assign cap_win   = mask_hit(s_addr_x, WIN_MASK, WIN_MATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      win_stb <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb  <= cap_take;
      win_stb <= cap_take & cap_win;
      if (cap_take) begin
        wr_addr <= s_addr;
        wr_data <= s_data;
      end
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> ($stable(wr_addr) && $stable(wr_data)));
  a_r6_span_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> span_hit(wr_addr_x, REG_LO, REG_HI));
  a_r7_window_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    win_stb |-> (wr_stb && mask_hit(wr_addr_x, WIN_MASK, WIN_MATCH)));

endmodule

// File: rtl/cbd_chip_enables.sv
module cbd_chip_enables
  import cbd_pkg::*;
#(
  parameter int unsigned AW        = 15,
  parameter logic [15:0] RAM_MASK  = 16'h6000,
  parameter logic [15:0] RAM_MATCH = 16'h6000
) (
  input  logic          m2,
  input  logic          rsel_n,
  input  logic [AW-1:0] addr,
  output logic          ram_ce,
  output logic          rom_ce
);

  localparam int unsigned PADW = BUS_AW - AW;

  logic [BUS_AW-1:0] addr_x;

  assign addr_x = {{PADW{1'b0}}, addr};
  assign ram_ce = m2 & rsel_n & mask_hit(addr_x, RAM_MASK, RAM_MATCH);
  assign rom_ce = ~rsel_n;

endmodule

// File: rtl/cart_bus_decoder.sv
module cart_bus_decoder #(
  parameter int unsigned AW        = 15,
  parameter int unsigned DW        = 8,
  parameter logic [15:0] REG_LO    = 16'h4020,
  parameter logic [15:0] REG_HI    = 16'h7FFF,
  parameter logic [15:0] WIN_MASK  = 16'h7000,
  parameter logic [15:0] WIN_MATCH = 16'h5000,
  parameter logic [15:0] RAM_MASK  = 16'h6000,
  parameter logic [15:0] RAM_MATCH = 16'h6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m2,
  input  logic          cpu_rw,
  input  logic          romsel_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          win_stb,
  output logic          ram_ce,
  output logic          rom_ce
);

  logic          s_rw;
  logic          s_rsel_n;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;
  logic          m2_fall;

  cbd_phase_sampler #(.AW(AW), .DW(DW)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .m2       (m2),
    .rw       (cpu_rw),
    .rsel_n   (romsel_n),
    .addr     (cpu_addr),
    .data     (cpu_data),
    .s_rw     (s_rw),
    .s_rsel_n (s_rsel_n),
    .s_addr   (s_addr),
    .s_data   (s_data),
    .m2_fall  (m2_fall)
  );

  cbd_write_capture #(
    .AW(AW), .DW(DW), .REG_LO(REG_LO), .REG_HI(REG_HI),
    .WIN_MASK(WIN_MASK), .WIN_MATCH(WIN_MATCH)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .m2_fall  (m2_fall),
    .s_rw     (s_rw),
    .s_rsel_n (s_rsel_n),
    .s_addr   (s_addr),
    .s_data   (s_data),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .win_stb  (win_stb)
  );

  cbd_chip_enables #(.AW(AW), .RAM_MASK(RAM_MASK), .RAM_MATCH(RAM_MATCH)) u_enables (
    .m2     (m2),
    .rsel_n (romsel_n),
    .addr   (cpu_addr),
    .ram_ce (ram_ce),
    .rom_ce (rom_ce)
  );

  // Port-level timing: a pulse follows one high sample then one low sample of M2.
  a_r2_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(m2, 2) && !$past(m2, 1)));
  a_r4_rom_half_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(romsel_n, 2));
  a_r5_reads_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !$past(cpu_rw, 2));

endmodule

// File: tb/cart_bus_decoder_tb_top.sv
module cart_bus_decoder_tb_top;

  localparam int LAG  = 8;
  localparam int LOWC = 10;
  localparam int HIC  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m2 = 1'b0;
  logic        cpu_rw = 1'b1;
  logic        romsel_n = 1'b1;
  logic [14:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        wr_stb, win_stb, ram_ce, rom_ce;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [23:0] exp_q[$];
  logic [14:0] last_addr = '0;
  logic [7:0]  last_data = '0;
  logic        prev_stb = 1'b0;

  always #2 clk = ~clk;

  cart_bus_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .m2(m2), .cpu_rw(cpu_rw), .romsel_n(romsel_n),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .win_stb(win_stb), .ram_ce(ram_ce), .rom_ce(rom_ce)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a strobe appears.
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        check(!prev_stb, "R2 pulse longer than one clock", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R4/R5/R6 unexpected strobe", int'(wr_addr), 0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          check(wr_addr == e[22:8], "R3 captured address", int'(wr_addr), int'(e[22:8]));
          check(wr_data == e[7:0], "R3 captured data", int'(wr_data), int'(e[7:0]));
          check(win_stb == e[23], "R7 window pulse", int'(win_stb), int'(e[23]));
        end
      end else begin
        check(!win_stb, "R7 window without strobe", int'(win_stb), 0);
      end
      prev_stb <= wr_stb;
    end
  end

  // Driver: one full M2 cycle, with ROM select following M2 LAG clocks late.
  task automatic bus_cycle(input logic [15:0] a, input logic rw, input logic [7:0] d);
    logic a15, exp_stb, exp_win, exp_ram;
    a15     = a[15];
    exp_stb = !rw && !a15 && (a >= 16'h4020);
    exp_win = ((a & 16'h7000) == 16'h5000);
    exp_ram = !a15 && ((a & 16'h6000) == 16'h6000);
    cpu_addr = a[14:0] ^ 15'h0155;
    cpu_data = ~d;
    cpu_rw   = ~rw;
    repeat (LOWC / 2) @(negedge clk);
    cpu_addr = a[14:0];
    cpu_data = d;
    cpu_rw   = rw;
    repeat (LOWC / 2) @(negedge clk);
    check(ram_ce == 1'b0, "R8 ram_ce low while M2 low", int'(ram_ce), 0);
    check(rom_ce == 1'b0, "R9 rom_ce follows romsel_n", int'(rom_ce), 0);
    m2 = 1'b1;
    repeat (LAG) @(negedge clk);
    romsel_n = ~a15;
    repeat (HIC) @(negedge clk);
    check(ram_ce == exp_ram, "R8 ram_ce in high phase", int'(ram_ce), int'(exp_ram));
    check(rom_ce == a15, "R9 rom_ce in high phase", int'(rom_ce), int'(a15));
    if (exp_stb) exp_q.push_back({exp_win, a[14:0], d});
    m2 = 1'b0;
    cpu_addr = a[14:0] ^ 15'h2AAA;
    cpu_data = d ^ 8'hFF;
    @(negedge clk);
    check(wr_stb == exp_stb, "R2/R4/R5/R6 strobe timing", int'(wr_stb), int'(exp_stb));
    if (exp_stb) begin
      last_addr = a[14:0];
      last_data = d;
    end
    repeat (LAG - 1) @(negedge clk);
    romsel_n = 1'b1;
    check(wr_addr == last_addr, "R3 address held", int'(wr_addr), int'(last_addr));
    check(wr_data == last_data, "R3 data held", int'(wr_data), int'(last_data));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(wr_stb == 1'b0 && win_stb == 1'b0, "R1 strobes low in reset", int'(wr_stb), 0);
    check(wr_addr == '0 && wr_data == '0, "R1 captured regs zero", int'(wr_addr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(wr_stb == 1'b0, "R1 idle after reset", int'(wr_stb), 0);
    bus_cycle(16'h5000, 1'b0, 8'hA5);  // R7 window, R2
    bus_cycle(16'h5FFF, 1'b0, 8'h3C);  // R7 top of window
    bus_cycle(16'h6000, 1'b0, 8'h11);  // R8 ram write, not in window
    bus_cycle(16'h7FFF, 1'b0, 8'hEE);  // R2 top of span
    bus_cycle(16'h4020, 1'b0, 8'h42);  // R6 lowest accepted
    bus_cycle(16'h401F, 1'b0, 8'h99);  // R6 just below
    bus_cycle(16'h4017, 1'b0, 8'h01);  // R6 console register
    bus_cycle(16'h8000, 1'b0, 8'h77);  // R4 rom half write
    bus_cycle(16'hE000, 1'b0, 8'h5A);  // R4, R8 stale romsel early
    bus_cycle(16'hD123, 1'b0, 8'h5B);  // R4 aliases 0x5123
    bus_cycle(16'h5800, 1'b1, 8'h22);  // R5 read in window
    bus_cycle(16'h6100, 1'b1, 8'h33);  // R5, R8 ram read
    bus_cycle(16'hC000, 1'b1, 8'h44);  // R9 rom read
    bus_cycle(16'h5123, 1'b0, 8'hC3);  // R3 new capture
    bus_cycle(16'h4800, 1'b0, 8'h0F);  // R7 miss, R2
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 every write strobed", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule